// File: doc/BRIEF.md
# Flash Status Byte Register

This block keeps the status byte that a flash device returns to its host during status reads. Five live indications feed it: a ready level and an auxiliary level from the write state machine, one-cycle pulses that flag an erase failure or a program failure, and the current sector-protect state. The two failure flags are sticky. The state machine can raise them but has no path to lower them. Only a clear-status strobe from the command decoder drops them.

The host reads through the active-low chip-enable and output-enable strobes, which the block samples on its clock. A read latches a fresh snapshot of the status bits at the first clock in which both strobes are seen low after at least one of them was high. Holding both strobes low freezes the presented value, so a polling host must toggle a strobe to observe progress.

The snapshot sits on data bits 7 down to 3, and bits 2 to 0 read as zero. A mode input selects how the rest of the bus is treated. In word mode the upper byte is driven as zero. In byte mode the upper lines are left undriven, because the pad logic uses the top line as an address input. The block only produces the per-bit drive enables; the tri-state pads are outside it.

Top module: `flash_status_reg`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `dq_out` equals 16'h0080. Bit 7 (ready) is 1 and bits 6 down to 0 are 0, whatever the failure flags held before reset.
- R2: Bit 7 of a snapshot equals `wsm_ready` and bit 6 equals `wsm_aux`, as sampled on the clock before the latching clock. The state machine can both set and clear these two bits.
- R3: A one-cycle `erase_fail_set` pulse sets bit 5. Bit 5 then stays 1 across any later `wsm_ready` or `wsm_aux` activity until `clr_status` is pulsed.
- R4: A one-cycle `prog_fail_set` pulse sets bit 4. Bit 4 then stays 1 until `clr_status` is pulsed.
- R5: A `clr_status` pulse clears bits 5 and 4 on the next clock. If a failure pulse arrives in the same cycle as the clear, the failure wins and its bit ends up 1.
- R6: Bit 3 of a snapshot equals `sector_locked` at the latching clock, and `clr_status` does not change it.
- R7: Bits 2 to 0 of `dq_out` are always 0.
- R8: A new snapshot is taken only at a clock where both `ce_n` and `oe_n` are low and at least one of them was high on the previous clock. Either strobe may fall last. While both stay low, `dq_out` does not change.
- R9: When `word_mode` is 1, bits 15 to 8 of `dq_out` are 0. During a read, all 16 enables in `dq_oe` are 1.
- R10: When `word_mode` is 0, bits 15 to 8 of `dq_oe` are 0. During a read, bits 7 to 0 of `dq_oe` are 1.
- R11: `dq_oe` is 1 only in the clock cycle after a clock at which both strobes were sampled low. Otherwise it is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up or wake from deep power-down) |
| wsm_ready | input | 1 | State machine idle (1) or busy (0) |
| wsm_aux | input | 1 | State machine auxiliary flag, shown on bit 6 |
| erase_fail_set | input | 1 | One-cycle pulse: erase failed |
| prog_fail_set | input | 1 | One-cycle pulse: program failed |
| clr_status | input | 1 | One-cycle pulse: host clear-status command |
| sector_locked | input | 1 | Sector-protect state, shown on bit 3 |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 selects a 16-bit bus, 0 selects an 8-bit bus |
| dq_out | output | BUS_W (16) | Data presented to the pads |
| dq_oe | output | BUS_W (16) | Per-bit pad drive enables |

## Verification
The bench builds the block with its default `BUS_W` of 16. This places both the padded word layout and the undriven byte layout on the same port pair. It sweeps all 64 combinations of ready level, auxiliary level, erase-fail pulse, program-fail pulse, protect state and bus mode. Each combination is read back with the strobe order chosen by the index, which reaches every status byte and both orders of strobe fall. Directed sequences add the frozen read, the same-cycle clear and failure, stickiness across state-machine activity, and a reset taken while the flags are set.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int BYTE_W   = 8;
    localparam int STAT_LSB = 3;

    // Status field as presented on bits 7..3
    typedef struct packed {
        logic ready;       // bit 7
        logic aux;         // bit 6
        logic erase_fail;  // bit 5
        logic prog_fail;   // bit 4
        logic protect;     // bit 3
    } stat_t;

    localparam stat_t STAT_RESET = '{ready: 1'b1, aux: 1'b0, erase_fail: 1'b0,
                                     prog_fail: 1'b0, protect: 1'b0};

    function automatic logic [BYTE_W-1:0] stat_to_byte(input stat_t s);
        return {s, {STAT_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/fsr_flags.sv
module fsr_flags
    import fsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wsm_ready,
    input  logic  wsm_aux,
    input  logic  erase_fail_set,
    input  logic  prog_fail_set,
    input  logic  clr_status,
    input  logic  sector_locked,
    output stat_t live
);

    logic ready_q;
    logic aux_q;
    logic ef_q;
    logic pf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= STAT_RESET.ready;
            aux_q   <= STAT_RESET.aux;
            ef_q    <= STAT_RESET.erase_fail;
            pf_q    <= STAT_RESET.prog_fail;
        end else begin
            ready_q <= wsm_ready;
            aux_q   <= wsm_aux;
            // a new failure beats a simultaneous clear
            ef_q    <= erase_fail_set | (ef_q & ~clr_status);
            pf_q    <= prog_fail_set  | (pf_q & ~clr_status);
        end
    end

    always_comb begin
        live.ready      = ready_q;
        live.aux        = aux_q;
        live.erase_fail = ef_q;
        live.prog_fail  = pf_q;
        live.protect    = sector_locked;
    end

endmodule

// File: rtl/fsr_strobe.sv
module fsr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    output logic latch_evt,
    output logic rd_active
);

    logic both_low;
    logic armed_q;
    logic rd_q;

    assign both_low = ~ce_n & ~oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            armed_q <= ~both_low;
            rd_q    <= both_low;
        end
    end

    assign latch_evt = both_low & armed_q;
    assign rd_active = rd_q;

endmodule

// File: rtl/fsr_snap.sv
module fsr_snap
    import fsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  latch_evt,
    input  stat_t live,
    output stat_t snap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= STAT_RESET;
        end else if (latch_evt) begin
            snap <= live;
        end
    end

endmodule

// File: rtl/fsr_pad.sv
module fsr_pad
    import fsr_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             word_mode,
    input  logic             rd_active,
    input  stat_t            snap,
    output logic [BUS_W-1:0] dq_out,
    output logic [BUS_W-1:0] dq_oe
);

    localparam int UPPER_W = BUS_W - BYTE_W;

    assign dq_out[BYTE_W-1:0] = stat_to_byte(snap);
    assign dq_oe[BYTE_W-1:0]  = {BYTE_W{rd_active}};

    generate
        if (UPPER_W > 0) begin : g_upper
            assign dq_out[BUS_W-1:BYTE_W] = '0;
            assign dq_oe[BUS_W-1:BYTE_W]  = {UPPER_W{rd_active & word_mode}};
        end
    endgenerate

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import fsr_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wsm_ready,
    input  logic             wsm_aux,
    input  logic             erase_fail_set,
    input  logic             prog_fail_set,
    input  logic             clr_status,
    input  logic             sector_locked,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             word_mode,
    output logic [BUS_W-1:0] dq_out,
    output logic [BUS_W-1:0] dq_oe
);

    stat_t live_stat;
    stat_t snap_stat;
    logic  latch_evt;
    logic  rd_active;

    fsr_flags u_flags (
        .clk            (clk),
        .rst            (rst),
        .wsm_ready      (wsm_ready),
        .wsm_aux        (wsm_aux),
        .erase_fail_set (erase_fail_set),
        .prog_fail_set  (prog_fail_set),
        .clr_status     (clr_status),
        .sector_locked  (sector_locked),
        .live           (live_stat)
    );

    fsr_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .latch_evt (latch_evt),
        .rd_active (rd_active)
    );

    fsr_snap u_snap (
        .clk       (clk),
        .rst       (rst),
        .latch_evt (latch_evt),
        .live      (live_stat),
        .snap      (snap_stat)
    );

    fsr_pad #(.BUS_W(BUS_W)) u_pad (
        .word_mode (word_mode),
        .rd_active (rd_active),
        .snap      (snap_stat),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ce_n,
    input logic             oe_n,
    input logic             clr_status,
    input logic             erase_fail_set,
    input logic             prog_fail_set,
    input logic             word_mode,
    input stat_t            live,
    input logic [BUS_W-1:0] dq_out,
    input logic [BUS_W-1:0] dq_oe
);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        dq_out[2:0] == 3'b000); // R7

    AST_EF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (live.erase_fail && !clr_status) |=> live.erase_fail); // R3

    AST_PF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (live.prog_fail && !clr_status) |=> live.prog_fail); // R4

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_status && !erase_fail_set && !prog_fail_set)
        |=> (!live.erase_fail && !live.prog_fail)); // R5

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && $past(!ce_n && !oe_n)) |=> $stable(dq_out)); // R8

    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        word_mode |-> ((dq_out >> BYTE_W) == '0)); // R9

    AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (rst)
        !word_mode |-> ((dq_oe >> BYTE_W) == '0)); // R10

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> (dq_oe == '0)); // R11

endmodule

bind flash_status_reg fsr_checker #(.BUS_W(BUS_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .clr_status     (clr_status),
    .erase_fail_set (erase_fail_set),
    .prog_fail_set  (prog_fail_set),
    .word_mode      (word_mode),
    .live           (live_stat),
    .dq_out         (dq_out),
    .dq_oe          (dq_oe)
);

// File: tb/flash_status_reg_test.sv
module flash_status_reg_test;

    localparam int BUS_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wsm_ready = 1'b1;
    logic wsm_aux = 1'b0;
    logic erase_fail_set = 1'b0;
    logic prog_fail_set = 1'b0;
    logic clr_status = 1'b0;
    logic sector_locked = 1'b0;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic word_mode = 1'b1;
    logic [BUS_W-1:0] dq_out;
    logic [BUS_W-1:0] dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5ns clk = ~clk;

    flash_status_reg #(.BUS_W(BUS_W)) uut (
        .clk            (clk),
        .rst            (rst),
        .wsm_ready      (wsm_ready),
        .wsm_aux        (wsm_aux),
        .erase_fail_set (erase_fail_set),
        .prog_fail_set  (prog_fail_set),
        .clr_status     (clr_status),
        .sector_locked  (sector_locked),
        .ce_n           (ce_n),
        .oe_n           (oe_n),
        .word_mode      (word_mode),
        .dq_out         (dq_out),
        .dq_oe          (dq_oe)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_byte(input bit r, input bit a, input bit e,
                                             input bit p, input bit k);
        return {8'h00, r, a, e, p, k, 3'b000};
    endfunction

    // read: strobes high, then fall in the chosen order; sample after latch
    task automatic do_read(input bit ce_last);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        if (ce_last) oe_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_read();
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset value, drivers off
        check16("R1", dq_out, 16'h0080);
        check16("R11", dq_oe, 16'h0000);
        rst = 1'b0;
        @(negedge clk);
        check16("R1", dq_out, 16'h0080);

        // exhaustive sweep of five status inputs and bus mode
        for (int v = 0; v < 64; v++) begin
            bit r, a, e, p, k, w;
            r = v[0]; a = v[1]; e = v[2]; p = v[3]; k = v[4]; w = v[5];
            @(negedge clk);
            pulse_clear();
            wsm_ready = r; wsm_aux = a; erase_fail_set = e; prog_fail_set = p;
            sector_locked = k; word_mode = w;
            @(negedge clk);
            erase_fail_set = 1'b0; prog_fail_set = 1'b0;
            do_read(v[0] ^ v[3]);
            // R2 R3 R4 R6 R7 lower byte
            check16("R2", {8'h00, dq_out[7:0]}, exp_byte(r, a, e, p, k));
            if (w) begin
                check16("R9", dq_out, exp_byte(r, a, e, p, k));
                check16("R9", dq_oe, 16'hFFFF);
            end else begin
                check16("R10", dq_oe, 16'h00FF);
            end
            end_read();
            check16("R11", dq_oe, 16'h0000);
        end

        // R3 sticky across WSM activity
        word_mode = 1'b1; sector_locked = 1'b0; wsm_aux = 1'b0; wsm_ready = 1'b1;
        pulse_clear();
        erase_fail_set = 1'b1;
        @(negedge clk); erase_fail_set = 1'b0;
        wsm_ready = 1'b0; wsm_aux = 1'b1;
        repeat (3) @(negedge clk);
        wsm_ready = 1'b1; wsm_aux = 1'b0;
        @(negedge clk);
        do_read(1'b1);
        check16("R3", dq_out, 16'h00A0);
        end_read();

        // R4 sticky, then R8 freeze while both strobes stay low
        prog_fail_set = 1'b1;
        @(negedge clk); prog_fail_set = 1'b0;
        do_read(1'b0);
        check16("R4", dq_out, 16'h00B0);
        wsm_ready = 1'b0; sector_locked = 1'b1;
        repeat (4) @(negedge clk);
        check16("R8", dq_out, 16'h00B0);
        oe_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        check16("R8", dq_out, 16'h0038);
        end_read();

        // R5 clear wins nothing over simultaneous failure; R6 protect kept
        wsm_ready = 1'b1;
        clr_status = 1'b1; erase_fail_set = 1'b1;
        @(negedge clk); clr_status = 1'b0; erase_fail_set = 1'b0;
        do_read(1'b1);
        check16("R5", dq_out, 16'h00A8);
        end_read();
        pulse_clear();
        do_read(1'b0);
        check16("R5", dq_out, 16'h0088);
        check16("R6", {15'h0, dq_out[3]}, 16'h0001);
        end_read();

        // R1 reset with flags set
        erase_fail_set = 1'b1; prog_fail_set = 1'b1;
        @(negedge clk); erase_fail_set = 1'b0; prog_fail_set = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check16("R1", dq_out, 16'h0080);
        do_read(1'b1);
        check16("R1", dq_out, 16'h0088);
        end_read();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule